// File: doc/BRIEF.md
# Two-Button Up/Down Counter with Turnaround Thresholds

This block turns two mechanical push-buttons into clean count commands for a 9-bit counter. Everything runs on a single system clock. Each raw button is first sampled through a two-flop synchronizer. A debouncer then accepts a new level only after the synchronized input has disagreed with the accepted level for a set number of consecutive clocks. An edge detector reduces each accepted press to a strobe that lasts one clock.

The counter register has a single driver and changes only on those strobes. The two buttons are not symmetric. The "up" button normally adds one, but once the count is above 399 it takes one away. The "down" button normally takes one away, but once the count is below 200 it adds one. The count therefore turns back near the top and bottom thresholds instead of wrapping. Both strobes are also brought out so a system can observe them.

Top module: `dual_button_counter`

## Requirements
- R1: A synchronous, active-high reset clears the count and both strobes to 0. It also clears the synchronizer, debouncer and edge-detector state, so a button that is still held when reset ends is treated as a fresh press.
- R2: When a raw button goes from 0 to 1 and stays there, its strobe is 1 in the clock cycle that follows the (HOLD+2)-th rising edge after the change. HOLD is the debounce parameter. The strobe is 0 after each earlier edge.
- R3: A raw input pulse that lasts fewer than HOLD clock cycles produces no strobe, and the count does not change.
- R4: Each accepted press gives exactly one strobe, one clock wide. Keeping the button held gives no further strobes, and releasing it gives none.
- R5: An up strobe, alone, with the count at 399 or below, makes the count one greater on the next rising edge.
- R6: An up strobe, alone, with the count above 399, makes the count one less on the next rising edge.
- R7: A down strobe, alone, with the count at 200 or above, makes the count one less on the next rising edge.
- R8: A down strobe, alone, with the count below 200, makes the count one greater on the next rising edge.
- R9: When up and down strobes are high in the same cycle, the count keeps its value.
- R10: The count changes at no edge except one that directly follows a strobe cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| btn_up_raw | input | 1 | Raw, asynchronous, bouncing "up" button (1 = pressed) |
| btn_dn_raw | input | 1 | Raw, asynchronous, bouncing "down" button (1 = pressed) |
| count | output | 9 | Current count value |
| up_stb | output | 1 | One-cycle strobe for each accepted up press |
| dn_stb | output | 1 | One-cycle strobe for each accepted down press |

## Verification
The bench drives the count up to and past 400 and then down to and past 199. A design with the comparisons off by one would turn back one step early or late, or would fail to oscillate between 399/400 and 199/200. Short glitches just under the hold length are injected; a debouncer that counted one cycle short would accept them and produce phantom counts. The bench also presses both buttons together, holds a button through reset, and measures the press-to-strobe latency exactly. These tests expose a design that lets one button win a tie, that keeps stale debouncer state across reset, or that drops or adds a synchronizer stage.

// File: rtl/dbc_pkg.sv
package dbc_pkg;

  localparam int unsigned CNT_W_DEF   = 9;
  localparam int unsigned HOLD_DEF    = 16;
  localparam int unsigned UP_TURN_DEF = 399;
  localparam int unsigned DN_TURN_DEF = 200;

  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_UP   = 2'b01,
    CMD_DN   = 2'b10,
    CMD_BOTH = 2'b11
  } cmd_e;

  // up request: climbs until above the turn point, then steps back
  function automatic int unsigned step_for_up(input int unsigned c, input int unsigned turn);
    return (c > turn) ? c - 1 : c + 1;
  endfunction

  // down request: descends until below the turn point, then steps back
  function automatic int unsigned step_for_dn(input int unsigned c, input int unsigned turn);
    return (c < turn) ? c + 1 : c - 1;
  endfunction

endpackage

// File: rtl/dbc_sync.sv
module dbc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/dbc_debounce.sv
module dbc_debounce #(
  parameter int unsigned HOLD = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_in,
  output logic lvl_out
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] run_len;
  logic          stable_lvl;
  logic          differs;
  logic          accept;

  assign differs = (lvl_in != stable_lvl);
  assign accept  = differs && (run_len == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len    <= '0;
      stable_lvl <= 1'b0;
    end else if (accept) begin
      run_len    <= '0;
      stable_lvl <= lvl_in;
    end else if (differs) begin
      run_len    <= run_len + 1'b1;
    end else begin
      run_len    <= '0;
    end
  end

  assign lvl_out = stable_lvl;

  // R3: the accepted level only ever moves to the value the input had
  a_r3_follows_input: assert property (@(posedge clk) disable iff (rst)
    (stable_lvl != $past(stable_lvl)) |-> (stable_lvl == $past(lvl_in)));

  // R3: the accepted level never moves while the input agrees with it
  a_r3_quiet_when_equal: assert property (@(posedge clk) disable iff (rst)
    (lvl_in == stable_lvl) |=> $stable(stable_lvl));
endmodule

// File: rtl/dbc_edge.sv
module dbc_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;

  // R4: a strobe lasts exactly one clock
  a_r4_one_wide: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/dbc_core.sv
module dbc_core
  import dbc_pkg::*;
#(
  parameter int unsigned CNT_W   = CNT_W_DEF,
  parameter int unsigned UP_TURN = UP_TURN_DEF,
  parameter int unsigned DN_TURN = DN_TURN_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_ev,
  input  logic             dn_ev,
  output logic [CNT_W-1:0] count
);
  cmd_e             cmd;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign cmd = cmd_e'({dn_ev, up_ev});

  always_comb begin
    unique case (cmd)
      CMD_UP:  cnt_d = CNT_W'(step_for_up(int'(cnt_q), UP_TURN));
      CMD_DN:  cnt_d = CNT_W'(step_for_dn(int'(cnt_q), DN_TURN));
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R5
  a_r5_up_climbs: assert property (@(posedge clk) disable iff (rst)
    (up_ev && !dn_ev && (cnt_q <= CNT_W'(UP_TURN))) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R6
  a_r6_up_turns: assert property (@(posedge clk) disable iff (rst)
    (up_ev && !dn_ev && (cnt_q > CNT_W'(UP_TURN))) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R7
  a_r7_dn_descends: assert property (@(posedge clk) disable iff (rst)
    (dn_ev && !up_ev && (cnt_q >= CNT_W'(DN_TURN))) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R8
  a_r8_dn_turns: assert property (@(posedge clk) disable iff (rst)
    (dn_ev && !up_ev && (cnt_q < CNT_W'(DN_TURN))) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R9
  a_r9_tie_holds: assert property (@(posedge clk) disable iff (rst)
    (up_ev && dn_ev) |=> $stable(cnt_q));
  // R10
  a_r10_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!up_ev && !dn_ev) |=> $stable(cnt_q));
endmodule

// File: rtl/dual_button_counter.sv
module dual_button_counter
  import dbc_pkg::*;
#(
  parameter int unsigned CNT_W       = CNT_W_DEF,
  parameter int unsigned HOLD        = HOLD_DEF,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned UP_TURN     = UP_TURN_DEF,
  parameter int unsigned DN_TURN     = DN_TURN_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             btn_up_raw,
  input  logic             btn_dn_raw,
  output logic [CNT_W-1:0] count,
  output logic             up_stb,
  output logic             dn_stb
);
  localparam int unsigned NBTN = 2;

  logic [NBTN-1:0] raw_vec;
  logic [NBTN-1:0] sync_vec;
  logic [NBTN-1:0] level_vec;
  logic [NBTN-1:0] stb_vec;

  assign raw_vec = {btn_dn_raw, btn_up_raw};

  for (genvar b = 0; b < NBTN; b++) begin : g_btn
    dbc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d_async(raw_vec[b]), .q_sync(sync_vec[b])
    );
    dbc_debounce #(.HOLD(HOLD)) u_deb (
      .clk(clk), .rst(rst), .lvl_in(sync_vec[b]), .lvl_out(level_vec[b])
    );
    dbc_edge u_edge (
      .clk(clk), .rst(rst), .lvl(level_vec[b]), .rise(stb_vec[b])
    );
  end

  dbc_core #(.CNT_W(CNT_W), .UP_TURN(UP_TURN), .DN_TURN(DN_TURN)) u_core (
    .clk(clk), .rst(rst), .up_ev(stb_vec[0]), .dn_ev(stb_vec[1]), .count(count)
  );

  assign up_stb = stb_vec[0];
  assign dn_stb = stb_vec[1];

  // R1: one clock out of reset, every output reads zero
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (count == '0 && !up_stb && !dn_stb));
endmodule

// File: tb/dual_button_counter_tb.sv
module dual_button_counter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 4;
  localparam int W = 9;

  logic clk = 0;
  logic rst = 1;
  logic bu = 0, bd = 0;
  logic [W-1:0] count;
  logic up_stb, dn_stb;

  int checks = 0, fails = 0;
  string cur_req = "R1";

  dual_button_counter #(.HOLD(HOLD)) u_dut (
    .clk(clk), .rst(rst), .btn_up_raw(bu), .btn_dn_raw(bd),
    .count(count), .up_stb(up_stb), .dn_stb(dn_stb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference: queues for synchronizer delay, integers for the rest
  int m_cnt = 0;
  bit m_lvl[2] = '{0, 0};
  bit m_prev[2] = '{0, 0};
  int m_run[2] = '{0, 0};
  bit uq[$] = '{0, 0};
  bit dq[$] = '{0, 0};

  function automatic bit m_stb(int i);
    return m_lvl[i] && !m_prev[i];
  endfunction

  always @(posedge clk) begin
    bit s[2];
    bit pu, pd;
    if (rst) begin
      m_cnt = 0; m_lvl = '{0, 0}; m_prev = '{0, 0}; m_run = '{0, 0};
      uq = '{0, 0}; dq = '{0, 0};
    end else begin
      pu = m_stb(0); pd = m_stb(1);
      if (pu && !pd)      m_cnt = (m_cnt > 399) ? m_cnt - 1 : m_cnt + 1;
      else if (pd && !pu) m_cnt = (m_cnt < 200) ? m_cnt + 1 : m_cnt - 1;
      m_prev[0] = m_lvl[0]; m_prev[1] = m_lvl[1];
      s[0] = uq[0]; s[1] = dq[0];
      for (int i = 0; i < 2; i++) begin
        if (s[i] != m_lvl[i]) begin
          m_run[i]++;
          if (m_run[i] == HOLD) begin m_lvl[i] = s[i]; m_run[i] = 0; end
        end else m_run[i] = 0;
      end
      void'(uq.pop_front()); uq.push_back(bu);
      void'(dq.pop_front()); dq.push_back(bd);
    end
  end

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // compared every cycle, away from the edge
  always @(negedge clk) if (!rst) begin
    chk(cur_req, int'(count), m_cnt, "count vs model");
    chk(cur_req, int'(up_stb), int'(m_stb(0)), "up_stb vs model");
    chk(cur_req, int'(dn_stb), int'(m_stb(1)), "dn_stb vs model");
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(bit up, bit dn);
    if (up) bu = 1;
    if (dn) bd = 1;
    cyc(HOLD + 4);
    bu = 0; bd = 0;
    cyc(HOLD + 4);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seen;
    cyc(3);
    chk("R1", int'(count), 0, "count in reset");
    chk("R1", int'(up_stb | dn_stb), 0, "strobes in reset");
    rst = 0;
    cyc(2);
    chk("R1", int'(count), 0, "count after reset");

    // R2 latency: strobe after exactly HOLD+2 edges
    cur_req = "R2";
    bu = 1;
    repeat (HOLD + 1) @(posedge clk);
    @(negedge clk);
    chk("R2", int'(up_stb), 0, "strobe before HOLD+2 edges");
    @(negedge clk);
    chk("R2", int'(up_stb), 1, "strobe at HOLD+2 edges");
    @(negedge clk);
    chk("R4", int'(up_stb), 0, "strobe one wide");
    chk("R5", int'(count), 1, "count after first up");
    cur_req = "R4";
    cyc(20);
    chk("R4", int'(count), 1, "held button no repeat");
    bu = 0; cyc(HOLD + 6);
    chk("R4", int'(count), 1, "release no strobe");

    // R3 bounce shorter than HOLD
    cur_req = "R3";
    for (int k = 0; k < 6; k++) begin
      bu = 1; bd = 1; cyc(HOLD - 1);
      bu = 0; bd = 0; cyc(2);
    end
    cyc(HOLD + 4);
    chk("R3", int'(count), 1, "glitches ignored");

    // R9 tie
    cur_req = "R9";
    bu = 1; bd = 1;
    seen = 0;
    for (int k = 0; k < HOLD + 6; k++) begin
      @(negedge clk);
      if (up_stb && dn_stb) seen++;
    end
    chk("R9", seen, 1, "simultaneous strobes");
    chk("R9", int'(count), 1, "tie leaves count");
    bu = 0; bd = 0; cyc(HOLD + 4);

    // R5 / R6 climb and turnaround
    cur_req = "R5";
    for (int k = 0; k < 398; k++) press(1, 0);
    chk("R5", int'(count), 399, "climb to 399");
    press(1, 0);
    chk("R5", int'(count), 400, "up at 399");
    cur_req = "R6";
    press(1, 0);
    chk("R6", int'(count), 399, "up above 399 turns back");
    press(1, 0); press(1, 0);
    chk("R6", int'(count), 399, "oscillation at top");

    // R7 / R8 descend and turnaround
    cur_req = "R7";
    for (int k = 0; k < 199; k++) press(0, 1);
    chk("R7", int'(count), 200, "descend to 200");
    press(0, 1);
    chk("R7", int'(count), 199, "down at 200");
    cur_req = "R8";
    press(0, 1);
    chk("R8", int'(count), 200, "down below 200 turns back");
    cur_req = "R10";
    cyc(30);
    chk("R10", int'(count), 200, "idle holds");

    // R1 reset with button held
    cur_req = "R1";
    bu = 1; cyc(HOLD + 6);
    rst = 1; cyc(2);
    chk("R1", int'(count), 0, "reset clears count");
    rst = 0;
    cyc(HOLD + 4);
    chk("R1", int'(count), 1, "held button re-accepted after reset");
    bu = 0; cyc(HOLD + 4);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule